// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a slave-only two-wire serial front end that gives a host byte-wide access to a small register file. The SCL and SDA line levels arrive as plain inputs. They are sampled in the system clock domain, pass through a two-flop synchronizer, and are then cleaned by a glitch filter whose length comes from the clock frequency. The block drives a single open-drain pull-down enable for SDA. START, repeated START and STOP are recognised as SDA edges while SCL is high.

A transfer begins with an identification byte. Its upper five bits carry a fixed device prefix, the next two bits must match two board strap pins, and the last bit selects the direction. A write sends a register address byte and then one data byte. A read first sets the register address with a write-direction header, then issues a repeated START and a read-direction identification byte. The slave then returns bytes from that address for as long as the master acknowledges them. Toward the register file the block presents an address, write data with a one-cycle write strobe, and a read-data input with a one-cycle strobe marking each byte it takes. For a fixed time after reset the block ignores START conditions.

Top module: `i2cr_slave`

## Requirements
- R1: An identification byte is acknowledged (SDA pulled low in the ninth clock) only when bits 7..3 equal 01010 and bits 2..1 equal strap_i[1:0]. Bit 0 selects the direction: 1 for read, 0 for write.
- R2: After a non-matching identification byte the slave leaves SDA released, acknowledges no later byte and issues no register write until the next START.
- R3: A write transfer is a START, a matching identification byte with bit 0 = 0, an address byte and a data byte. The slave acknowledges all three bytes and gives exactly one reg_we_o pulse, with reg_addr_o equal to the address byte and reg_wdata_o equal to the data byte.
- R4: Any byte that follows the data byte of a write is not acknowledged and causes no register write.
- R5: A read transfer is a write-direction header, an address byte, a repeated START and a read-direction identification byte, all acknowledged. The slave then shifts out the register at that address, most significant bit first, changing SDA only while SCL is low.
- R6: While the master acknowledges, every further read byte comes from the same address, and each byte is marked by one reg_re_o pulse. After a master NACK the slave releases SDA and drives nothing until the next START.
- R7: A STOP returns the slave to idle. Bytes clocked after a STOP without a new START are neither acknowledged nor written.
- R8: A START that arrives within PWRUP_CYCLES clock cycles after reset is ignored, and the transfer that follows it is not acknowledged.
- R9: Pulses on SCL or SDA shorter than the filter length (at least 50 ns) have no effect on the transfer.
- R10: During and just after reset, sda_drive_o, reg_we_o and reg_re_o are 0, and reg_we_o and reg_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 2 | Address strap levels, matched against identification bits 2..1 |
| sda_drive_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 8 | Current register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |
| reg_re_o | output | 1 | One-cycle strobe when a read byte is taken |

## Verification
The bench covers four groups of corner cases. The first is the header: a wrong strap value, a wrong prefix, and a START that lands in the power-up window. A design that got these wrong would acknowledge a foreign or premature address. The second is where a write ends. A surplus byte after the data byte, and bytes clocked after a STOP with no new START, expose a design that keeps writing or acknowledging. The third is the read path: a repeated START, several bytes from one address, and a NACK followed by more clocks. Faults here show up as the address advancing, a missing read strobe, or SDA still driven after the NACK. The last group injects short pulses on SCL during its low phase and on SDA during its high phase. An unfiltered design would count an extra bit, or see a false START or STOP, and drop the write.

// File: rtl/i2cr_pkg.sv
// Package: shared types and constants of the register access slave.
// Assumes one byte-wide register address and byte-wide data.
package i2cr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_PREFIX = 5'b01010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } eng_state_t;

    typedef enum logic [2:0] {
        K_ID,
        K_ADDR,
        K_DATA,
        K_RD,
        K_DONE
    } byte_kind_t;
endpackage

// File: rtl/i2cr_filter.sv
// Module: line conditioner for one bus wire.
// Synchronises the raw level with two flops, then changes its output only
// after the synchronised level has differed for FILT_LEN consecutive clocks.
// Assumes the idle bus level is high.
module i2cr_filter #(
    parameter int FILT_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] run_q;

    // Two-flop synchroniser into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
        end
    end

    // Accept a new level only after it has persisted FILT_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            line_o <= 1'b1;
        end else if (s2_q == line_o) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            line_o <= s2_q;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9
    filt_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(s2_q) == line_o && $past(s2_q, 2) == line_o));
endmodule

// File: rtl/i2cr_busevt.sv
// Module: bus condition detector.
// Turns the filtered SCL and SDA levels into one-cycle event pulses: SCL rise,
// SCL fall, START (SDA falls while SCL high) and STOP (SDA rises while SCL high).
// Assumes both inputs come through filters of equal latency.
module i2cr_busevt (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, sda_d;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Decode edges; SDA edges count only while SCL stays high.
    always_comb begin
        scl_rise = scl_f & ~scl_d;
        scl_fall = ~scl_f & scl_d;
        start_ev = scl_f & scl_d & sda_d & ~sda_f;
        stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
    end
endmodule

// File: rtl/i2cr_engine.sv
// Module: protocol engine of the register access slave.
// Receives the identification, address and data bytes, generates the
// acknowledge slots, shifts read data out MSB first and drives the register
// port. Assumes event inputs are one-cycle pulses from i2cr_busevt and that
// reg_rdata_i reflects reg_addr_o combinationally or at least one cycle early.
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter int PWRUP_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_bit,
    input  logic [1:0]        strap_i,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o
);
    localparam int PW_W = $clog2(PWRUP_CYCLES + 1);
    localparam int BC_W = $clog2(BYTE_W + 1);

    eng_state_t        state_q;
    byte_kind_t        kind_q;
    logic [BC_W-1:0]   bit_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [PW_W-1:0]   pw_q;
    logic              pwr_ok;
    logic              id_match;

    assign pwr_ok   = (pw_q == PW_W'(PWRUP_CYCLES));
    assign id_match = (shreg_q[7:3] == DEV_PREFIX) && (shreg_q[2:1] == strap_i);

    // Power-up window: count cycles after reset until STARTs are honoured.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pw_q <= '0;
        else if (!pwr_ok)
            pw_q <= pw_q + 1'b1;
    end

    // Transfer state machine, shift register and register-port strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_q      <= K_ID;
            bit_q       <= '0;
            shreg_q     <= '0;
            sda_oe      <= 1'b0;
            reg_addr_o  <= '0;
            reg_wdata_o <= '0;
            reg_we_o    <= 1'b0;
            reg_re_o    <= 1'b0;
        end else begin
            reg_we_o <= 1'b0;
            reg_re_o <= 1'b0;
            if (start_ev && pwr_ok) begin
                state_q <= ST_RX;
                kind_q  <= K_ID;
                bit_q   <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                case (state_q)
                    ST_RX: begin
                        if (scl_rise && bit_q != BC_W'(BYTE_W)) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_bit};
                            bit_q   <= bit_q + 1'b1;
                        end else if (scl_fall && bit_q == BC_W'(BYTE_W)) begin
                            case (kind_q)
                                K_ID: begin
                                    if (id_match) begin
                                        sda_oe  <= 1'b1;
                                        state_q <= ST_ACK;
                                        kind_q  <= shreg_q[0] ? K_RD : K_ADDR;
                                    end else begin
                                        state_q <= ST_IGNORE;
                                    end
                                end
                                K_ADDR: begin
                                    reg_addr_o <= shreg_q;
                                    sda_oe     <= 1'b1;
                                    state_q    <= ST_ACK;
                                    kind_q     <= K_DATA;
                                end
                                K_DATA: begin
                                    reg_wdata_o <= shreg_q;
                                    reg_we_o    <= 1'b1;
                                    sda_oe      <= 1'b1;
                                    state_q     <= ST_ACK;
                                    kind_q      <= K_DONE;
                                end
                                default: state_q <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_q <= '0;
                            if (kind_q == K_RD) begin
                                shreg_q  <= reg_rdata_i;
                                sda_oe   <= ~reg_rdata_i[BYTE_W-1];
                                reg_re_o <= 1'b1;
                                bit_q    <= BC_W'(1);
                                state_q  <= ST_TX;
                            end else if (kind_q == K_DONE) begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_IGNORE;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_q == BC_W'(BYTE_W)) begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_MACK;
                            end else begin
                                sda_oe  <= ~shreg_q[BYTE_W-2];
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                                bit_q   <= bit_q + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (sda_bit)
                                state_q <= ST_IDLE;
                            else begin
                                kind_q  <= K_RD;
                                state_q <= ST_ACK;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);
    // R6
    mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MACK) |-> !sda_oe);
    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> (!sda_oe && !reg_we_o));
    // R8
    pwrup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (state_q == ST_IDLE && !sda_oe));
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_o && reg_re_o));
endmodule

// File: rtl/i2cr_slave.sv
// Module: top of the register access slave.
// Conditions both bus lines, detects bus conditions and runs the protocol
// engine. Assumes clk is CLK_HZ; the glitch filter covers at least FILT_NS.
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter int CLK_HZ       = 125_000_000,
    parameter int FILT_NS      = 50,
    parameter int PWRUP_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_drive_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              reg_re_o
);
    localparam int FILT_RAW = ((CLK_HZ / 1_000_000) * FILT_NS + 999) / 1000;
    localparam int FILT_LEN = (FILT_RAW < 2) ? 2 : FILT_RAW;

    logic [1:0] raw_lines, clean_lines;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cr_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2cr_busevt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (clean_lines[0]),
        .sda_f    (clean_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cr_engine #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_ev    (start_ev),
        .stop_ev     (stop_ev),
        .sda_bit     (clean_lines[1]),
        .strap_i     (strap_i),
        .reg_rdata_i (reg_rdata_i),
        .sda_oe      (sda_drive_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_we_o    (reg_we_o),
        .reg_re_o    (reg_re_o)
    );
endmodule

// File: tb/i2cr_slave_tb.sv
// Bench: a behavioural bus master plus a reference model of the expected
// register contents and write stream. Every write strobe is compared with the
// model on each clock; acks and read bytes are compared per byte.
module i2cr_slave_tb;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_drive;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    wire        sda_line = sda_m & ~sda_drive;

    logic [7:0] mem [4];
    logic [7:0] exp_mem [4];
    logic [15:0] exp_wq [$];
    int vectors = 0;
    int miscompares = 0;
    int re_count = 0;

    always #4 clk = ~clk;

    i2cr_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .sda_drive_o (sda_drive),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_rdata_i (reg_rdata),
        .reg_re_o    (reg_re)
    );

    assign reg_rdata = mem[reg_addr[1:0]];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the write stream against the model (R3, R4, R2).
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_wq.size() == 0)
                check(0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
                logic [15:0] e;
                e = exp_wq.pop_front();
                check({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
            end
            mem[reg_addr[1:0]] = reg_wdata;
        end
        if (rst_n && reg_re) re_count++;
        if (rst_n) check(!(reg_we && reg_re), "R10 strobes exclusive", {reg_we, reg_re}, 0);
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        scl_m = 1'b0; wq(); sda_m = 1'b1; wq();
        scl_m = 1'b1; wq(); sda_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wq(); sda_m = 1'b0; wq();
        scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; wq();
            sda_m = b[i];
            if (glitch) begin
                scl_m = 1'b1; repeat (3) @(negedge clk); scl_m = 1'b0;
            end
            wq();
            scl_m = 1'b1; wq();
            if (glitch) begin
                sda_m = ~b[i]; repeat (3) @(negedge clk); sda_m = b[i];
            end
            wq();
        end
        scl_m = 1'b0; wq(); sda_m = 1'b1; wq();
        scl_m = 1'b1; wq(); ack = ~sda_line; wq();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; wq(); sda_m = 1'b1; wq();
            scl_m = 1'b1; wq(); d[i] = sda_line; wq();
        end
        scl_m = 1'b0; wq(); sda_m = mack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq(); wq();
    endtask

    function automatic logic [7:0] id_byte(input logic [1:0] s, input bit rd);
        return {5'b01010, s, rd};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit glitch, input string req);
        bit k;
        bus_start();
        send_byte(id_byte(strap, 1'b0), glitch, k); check(k, {req, " id ack"}, k, 1);
        send_byte(a, glitch, k); check(k, {req, " addr ack"}, k, 1);
        exp_wq.push_back({a, d});
        exp_mem[a[1:0]] = d;
        send_byte(d, glitch, k); check(k, {req, " data ack"}, k, 1);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] a, input int n, input string req);
        bit k;
        logic [7:0] d;
        int re0;
        bus_start();
        send_byte(id_byte(strap, 1'b0), 1'b0, k); check(k, {req, " id ack"}, k, 1);
        send_byte(a, 1'b0, k); check(k, {req, " addr ack"}, k, 1);
        bus_rstart();
        send_byte(id_byte(strap, 1'b1), 1'b0, k); check(k, {req, " read id ack"}, k, 1);
        re0 = re_count;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check(d == exp_mem[a[1:0]], {req, " read data"}, d, exp_mem[a[1:0]]);
        end
        check(re_count - re0 == n, "R6 read strobes", re_count - re0, n);
        // R6: after the NACK the slave must not drive the next byte slot.
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R6 released after NACK", d, 8'hFF);
        check(re_count - re0 == n, "R6 no strobe after NACK", re_count - re0, n);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        bit k;
        for (int i = 0; i < 4; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (5) @(negedge clk);
        // R10: reset state
        check(sda_drive == 1'b0, "R10 reset sda_drive", sda_drive, 0);
        check(reg_we == 1'b0 && reg_re == 1'b0, "R10 reset strobes", {reg_we, reg_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sda_drive == 1'b0, "R10 after reset sda_drive", sda_drive, 0);
        // R8: START inside the power-up window is ignored
        bus_start();
        send_byte(id_byte(strap, 1'b0), 1'b0, k); check(!k, "R8 no ack in power-up", k, 0);
        send_byte(8'h01, 1'b0, k); check(!k, "R8 addr ignored", k, 0);
        bus_stop();
        // R3: plain write
        do_write(8'h02, 8'hA5, 1'b0, "R3");
        // R1: wrong strap bits and wrong prefix; R2: rest ignored
        bus_start();
        send_byte(id_byte(2'b01, 1'b0), 1'b0, k); check(!k, "R1 strap mismatch nack", k, 0);
        send_byte(8'h02, 1'b0, k); check(!k, "R2 addr after mismatch", k, 0);
        send_byte(8'h11, 1'b0, k); check(!k, "R2 data after mismatch", k, 0);
        bus_stop();
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, 1'b0, k); check(!k, "R1 prefix mismatch nack", k, 0);
        bus_stop();
        // R1: other strap setting accepted
        strap = 2'b01;
        do_write(8'h01, 8'h3C, 1'b0, "R1");
        // R4: surplus byte after data
        bus_start();
        send_byte(id_byte(strap, 1'b0), 1'b0, k); check(k, "R4 id ack", k, 1);
        send_byte(8'h00, 1'b0, k); check(k, "R4 addr ack", k, 1);
        exp_wq.push_back({8'h00, 8'h81}); exp_mem[0] = 8'h81;
        send_byte(8'h81, 1'b0, k); check(k, "R4 data ack", k, 1);
        send_byte(8'h77, 1'b0, k); check(!k, "R4 surplus nack", k, 0);
        bus_stop();
        // R5: single-byte read
        do_read(8'h02, 1, "R5");
        // R6: multi-byte read from one address
        do_read(8'h00, 3, "R6");
        do_read(8'h01, 2, "R6");
        // R7: STOP then bytes without START
        bus_start();
        send_byte(id_byte(strap, 1'b0), 1'b0, k); check(k, "R7 id ack", k, 1);
        send_byte(8'h03, 1'b0, k); check(k, "R7 addr ack", k, 1);
        bus_stop();
        send_byte(8'h55, 1'b0, k); check(!k, "R7 no ack after stop", k, 0);
        send_byte(8'h66, 1'b0, k); check(!k, "R7 still idle", k, 0);
        bus_stop();
        // R9: short pulses on both lines during a write
        do_write(8'h03, 8'h5A, 1'b1, "R9");
        do_read(8'h03, 1, "R9");
        repeat (20) @(negedge clk);
        check(exp_wq.size() == 0, "R3 all writes seen", exp_wq.size(), 0);
        for (int i = 0; i < 4; i++)
            check(mem[i] == exp_mem[i], "R3 register contents", mem[i], exp_mem[i]);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule